// File: doc/BRIEF.md
# Double-Buffered Four-Channel Converter Code Register

This block stores the digital codes for four converter channels. Every channel has two registers in series. A staging register takes host writes. A live register drives the converter code. The host writes a staging register through a plain write port made of an address, data and a strobe. The live registers change only on a load event. That load is applied together to every selected channel whose staging register holds data not yet transferred, so several outputs can change on the same clock.

A mode input selects where the load event comes from. When it is high, a falling edge on an asynchronous active-low load pin is the trigger; the pin passes through a two-flop synchroniser before its edge is detected. When it is low, a one-cycle software load command with a per-channel mask is the trigger. After reset every live code is zero, and a code stays zero until data written to that channel has been loaded. The code width is a parameter (8, 10 or 12 bits).

Top module: `quad_dac_regbank`

## Requirements
- R1: While reset is asserted, and right after it, all four live codes read zero and all pending flags read zero.
- R2: A write with `wr_addr` = n (0 selects channel A, up to 3 for channel D) loads that channel's staging register and sets `pending[n]` at the next clock edge. No live code changes.
- R3: With `pin_load_en` high, if `ldac_n` is first sampled low at rising edge k after being high at edge k-1, the live registers of all pending channels take their staging values at edge k+2.
- R4: A load event leaves alone every channel whose pending flag is clear. A channel that has never been written keeps its code at zero.
- R5: Holding `ldac_n` low gives exactly one load. A write made while the pin stays low is not transferred until the next high-to-low transition.
- R6: With `pin_load_en` low, transitions on `ldac_n` cause no load.
- R7: With `pin_load_en` low, a cycle with `sw_load` high loads only the channels that have their `sw_mask` bit set (bit n for channel n) and are pending. The new code is visible after that same clock edge.
- R8: With `pin_load_en` high, `sw_load` has no effect.
- R9: Loading a channel clears its pending flag, unless the same channel is written in the same cycle.
- R10: When a write and a load hit the same channel in one cycle, the live register takes the old staging value. The pending flag stays set, so a later load transfers the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for a staging register |
| wr_addr | input | ADDR_W (2) | Channel select, 0 = A to 3 = D |
| wr_data | input | CODE_W | Code to stage |
| sw_load | input | 1 | Software load command, one cycle |
| sw_mask | input | NUM_CH | Channels the software load may update |
| pin_load_en | input | 1 | 1: the pin triggers loads; 0: software triggers loads |
| ldac_n | input | 1 | Asynchronous active-low load pin, acts on its falling edge |
| dac_code | output | NUM_CH*CODE_W | Live codes, channel n at bits n*CODE_W upward |
| pending | output | NUM_CH | Per-channel flag: staged data not yet loaded |

## Verification
A host write and a load event can fall in the same cycle on the same channel. The write sets the pending flag, and the load wants to clear that flag and copy the staging register. The bench forces this by raising `wr_en` and `sw_load` on one clock for one channel. It then checks that the live code shows the previous staged value, that `pending` is still set, and that one more load brings out the new value. Random phases let writes land on pin-derived load edges as well. A reference model that steps every clock decides the outcome.

// File: rtl/dac_regbank_pkg.sv
package dac_regbank_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SW   = 2'd1,
    SRC_PIN  = 2'd2
  } load_src_e;

  // choose the single source of a load event for this cycle
  function automatic load_src_e pick_src(input logic pin_mode,
                                         input logic pin_fall,
                                         input logic sw_cmd);
    load_src_e s;
    s = SRC_NONE;
    if (pin_mode) begin
      if (pin_fall) s = SRC_PIN;
    end else if (sw_cmd) begin
      s = SRC_SW;
    end
    return s;
  endfunction

  // a fresh write wins over a load clearing the flag
  function automatic logic next_pending(input logic wr,
                                        input logic ld,
                                        input logic cur);
    logic n;
    n = cur;
    if (wr)      n = 1'b1;
    else if (ld) n = 1'b0;
    return n;
  endfunction

endpackage

// File: rtl/dac_load_sync.sv
module dac_load_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ldac_n,
  output logic fall_o
);
  localparam int CHAIN_W = STAGES + 1;

  // [STAGES-1:0] synchronise, [STAGES] keeps the previous synchronised level
  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[CHAIN_W-2:0], ldac_n};
  end

  assign fall_o = chain_q[CHAIN_W-1] & ~chain_q[CHAIN_W-2];

endmodule

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl
  import dac_regbank_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              pin_mode,
  input  logic              pin_fall,
  input  logic              sw_cmd,
  input  logic [NUM_CH-1:0] sw_mask,
  input  logic [NUM_CH-1:0] pending,
  output logic [NUM_CH-1:0] event_vec,
  output logic [NUM_CH-1:0] load_vec
);
  load_src_e src;

  always_comb begin
    src = pick_src(pin_mode, pin_fall, sw_cmd);
    unique case (src)
      SRC_PIN: event_vec = '1;
      SRC_SW:  event_vec = sw_mask;
      default: event_vec = '0;
    endcase
  end

  // only channels with untransferred data are touched
  assign load_vec = event_vec & pending;

endmodule

// File: rtl/dac_chan.sv
module dac_chan
  import dac_regbank_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              load,
  output logic [CODE_W-1:0] code_o,
  output logic              pend_o
);
  logic [CODE_W-1:0] stage_q;
  logic [CODE_W-1:0] live_q;
  logic              pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      live_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (load)   live_q  <= stage_q;   // old staged value on a collision
      if (wr_hit) stage_q <= wr_data;
      pend_q <= next_pending(wr_hit, load, pend_q);
    end
  end

  assign code_o = live_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank #(
  parameter  int NUM_CH      = 4,
  parameter  int CODE_W      = 12,
  parameter  int SYNC_STAGES = 2,
  localparam int ADDR_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CODE_W-1:0]        wr_data,
  input  logic                     sw_load,
  input  logic [NUM_CH-1:0]        sw_mask,
  input  logic                     pin_load_en,
  input  logic                     ldac_n,
  output logic [NUM_CH*CODE_W-1:0] dac_code,
  output logic [NUM_CH-1:0]        pending
);
  // named internal events, visible to the bound checker
  logic              pin_fall;
  logic [NUM_CH-1:0] wr_hit;
  logic [NUM_CH-1:0] event_vec;
  logic [NUM_CH-1:0] load_vec;

  dac_load_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .ldac_n (ldac_n),
    .fall_o (pin_fall)
  );

  dac_load_ctrl #(.NUM_CH(NUM_CH)) i_ctrl (
    .pin_mode  (pin_load_en),
    .pin_fall  (pin_fall),
    .sw_cmd    (sw_load),
    .sw_mask   (sw_mask),
    .pending   (pending),
    .event_vec (event_vec),
    .load_vec  (load_vec)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign wr_hit[c] = wr_en && (wr_addr == ADDR_W'(c));

    dac_chan #(.CODE_W(CODE_W)) i_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (wr_hit[c]),
      .wr_data (wr_data),
      .load    (load_vec[c]),
      .code_o  (dac_code[c*CODE_W +: CODE_W]),
      .pend_o  (pending[c])
    );
  end

endmodule

// File: rtl/dac_regbank_chk.sv
module dac_regbank_chk #(
  parameter  int NUM_CH = 4,
  parameter  int CODE_W = 12,
  localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic                     sw_load,
  input logic                     pin_load_en,
  input logic [NUM_CH*CODE_W-1:0] dac_code,
  input logic [NUM_CH-1:0]        pending,
  input logic [NUM_CH-1:0]        load_vec
);

  always @(negedge clk) begin
    if (!rst_n) begin
      // R1
      reset_clear_chk: assert (dac_code == '0 && pending == '0)
        else $error("live codes or pending not cleared in reset");
    end
  end

  // R2
  stable_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_vec == '0) |=> $stable(dac_code))
    else $error("live code moved without a load");

  // R7
  no_source_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_load_en && !sw_load) |-> (load_vec == '0))
    else $error("load without a software command in software mode");

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R2
    write_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(c)) |=> pending[c])
      else $error("write did not mark channel pending");

    // R9
    load_clears_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_vec[c] && !(wr_en && wr_addr == ADDR_W'(c))) |=> !pending[c])
      else $error("load left pending set");

    // R4
    load_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_vec[c] |-> pending[c])
      else $error("load of a channel with nothing new");

    // R10
    collision_keeps_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_vec[c] && wr_en && wr_addr == ADDR_W'(c)) |=> pending[c])
      else $error("collision lost the fresh write");
  end

endmodule

bind quad_dac_regbank dac_regbank_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .sw_load     (sw_load),
  .pin_load_en (pin_load_en),
  .dac_code    (dac_code),
  .pending     (pending),
  .load_vec    (load_vec)
);

// File: tb/test_quad_dac_regbank.sv
module test_quad_dac_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic          sw_load = 1'b0;
  logic [NC-1:0] sw_mask = '0;
  logic          pin_load_en = 1'b0;
  logic          ldac_n = 1'b1;
  logic [NC*CW-1:0] dac_code;
  logic [NC-1:0]    pending;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;
  string tag = "R1";

  quad_dac_regbank i_quad_dac_regbank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sw_load(sw_load), .sw_mask(sw_mask),
    .pin_load_en(pin_load_en), .ldac_n(ldac_n),
    .dac_code(dac_code), .pending(pending)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int unsigned m_stage[NC];
  int unsigned m_live[NC];
  bit          m_pend[NC];
  bit          pin_hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        m_stage[c] = 0; m_live[c] = 0; m_pend[c] = 0;
      end
      pin_hist = '{1'b1, 1'b1, 1'b1};
    end else begin
      bit fall;
      bit [NC-1:0] ev;
      // pin level seen two and three edges ago decides the edge
      fall = (pin_hist[pin_hist.size()-3] == 1'b1) && (pin_hist[pin_hist.size()-2] == 1'b0);
      if (pin_load_en) ev = fall ? '1 : '0;
      else             ev = sw_load ? sw_mask : '0;
      for (int c = 0; c < NC; c++) begin
        bit ld, wr;
        ld = ev[c] && m_pend[c];
        wr = wr_en && (int'(wr_addr) == c);
        if (ld) m_live[c] = m_stage[c];
        if (wr) begin m_stage[c] = wr_data; m_pend[c] = 1'b1; end
        else if (ld) m_pend[c] = 1'b0;
      end
      pin_hist.push_back(ldac_n);
      if (pin_hist.size() > 8) void'(pin_hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      bit bad;
      bad = 1'b0;
      for (int c = 0; c < NC; c++) begin
        if (int'(dac_code[c*CW +: CW]) != m_live[c] || pending[c] != m_pend[c]) bad = 1'b1;
      end
      checks++;
      if (bad) begin
        errors++;
        $display("FAIL %s model: code=%h pend=%b exp=%h %h %h %h pend=%b%b%b%b", tag,
                 dac_code, pending, m_live[3], m_live[2], m_live[1], m_live[0],
                 m_pend[3], m_pend[2], m_pend[1], m_pend[0]);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int unsigned code_of(int c);
    return int'(dac_code[c*CW +: CW]);
  endfunction

  task automatic do_write(int c, int unsigned d);
    wr_en = 1'b1; wr_addr = 2'(c); wr_data = CW'(d);
    step();
    wr_en = 1'b0;
  endtask

  task automatic do_sw(logic [NC-1:0] m);
    sw_load = 1'b1; sw_mask = m;
    step();
    sw_load = 1'b0; sw_mask = '0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    step(3);
    // R1 reset state
    chk("R1", int'(dac_code == '0), 1);
    chk("R1", int'(pending), 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    step();
    chk("R1", int'(dac_code == '0), 1);

    // R2 writes stage only
    tag = "R2";
    do_write(0, 'h123);
    do_write(2, 'hABC);
    chk("R2", int'(pending), 'b0101);
    chk("R2", int'(dac_code == '0), 1);

    // R7 / R9 masked software load
    tag = "R7";
    do_sw(4'b0001);
    chk("R7", code_of(0), 'h123);
    chk("R7", code_of(2), 0);
    chk("R9", int'(pending), 'b0100);

    // R4 full mask, unwritten channels stay zero
    tag = "R4";
    do_sw(4'b1111);
    chk("R4", code_of(2), 'hABC);
    chk("R4", code_of(1), 0);
    chk("R4", code_of(3), 0);
    chk("R4", code_of(0), 'h123);

    // R8 software command ignored in pin mode
    tag = "R8";
    pin_load_en = 1'b1;
    step();
    do_write(1, 'h055);
    do_sw(4'b1111);
    chk("R8", code_of(1), 0);
    chk("R8", int'(pending), 'b0010);

    // R3 pin latency: low first sampled at edge k, load at k+2
    tag = "R3";
    ldac_n = 1'b0;
    step();
    chk("R3", code_of(1), 0);
    step();
    chk("R3", code_of(1), 0);
    step();
    chk("R3", code_of(1), 'h055);
    chk("R3", int'(pending), 0);

    // R5 held low gives one load only
    tag = "R5";
    do_write(3, 'h777);
    step(5);
    chk("R5", code_of(3), 0);
    chk("R5", int'(pending), 'b1000);
    ldac_n = 1'b1;
    step(3);
    ldac_n = 1'b0;
    step(3);
    chk("R5", code_of(3), 'h777);
    ldac_n = 1'b1;
    step(3);

    // R6 pin ignored in software mode
    tag = "R6";
    pin_load_en = 1'b0;
    do_write(0, 'h321);
    ldac_n = 1'b0;
    step(4);
    ldac_n = 1'b1;
    step(4);
    chk("R6", code_of(0), 'h123);
    chk("R6", int'(pending), 'b0001);

    // R10 write and load on one channel in one cycle
    tag = "R10";
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 'h456;
    sw_load = 1'b1; sw_mask = 4'b0001;
    step();
    wr_en = 1'b0; sw_load = 1'b0; sw_mask = '0;
    chk("R10", code_of(0), 'h321);
    chk("R10", int'(pending[0]), 1);
    do_sw(4'b0001);
    chk("R10", code_of(0), 'h456);
    chk("R9", int'(pending[0]), 0);

    // random mix, judged by the model every clock
    tag = "R2/R3/R7/R10 random";
    for (int i = 0; i < 600; i++) begin
      if (i % 75 == 0) pin_load_en = ($urandom % 2) == 1;
      wr_en   = ($urandom % 10) < 4;
      wr_addr = 2'($urandom % 4);
      wr_data = CW'($urandom);
      sw_load = ($urandom % 10) < 2;
      sw_mask = NC'($urandom);
      if (($urandom % 4) == 0) ldac_n = ~ldac_n;
      step();
    end
    wr_en = 1'b0; sw_load = 1'b0;
    step(2);
    finish_run();
  end

endmodule